// File: doc/BRIEF.md
# Banked Maskable Interrupt Controller

This block collects level-sensitive interrupt lines, organised as banks of 32, and merges them into one interrupt request toward a processor. Each line first passes through a two-flop synchroniser. Each bank keeps its own mask register. Software changes the mask only through two write-only aliases. A write of ones to one alias sets mask bits, and a write of ones to the other clears them. A pending view shows, for each bank, which synchronised lines are both high and not masked.

Once the request output rises, it stays high until software writes an acknowledge bit in the control word. The controller then drops the request for one cycle. After that it looks at the pending sources again and raises the request once more if any of them is still active. Software reaches the registers over a plain 32-bit read/write bus addressed in words. Read data is registered.

Top module: `intc_banked`

## Requirements
- R1: After reset every mask bit of every bank is 1, `irq_out` is 0 and `rdata` is 0.
- R2: The bank status word (slot 0) reads back the level of that bank's 32 inputs, delayed by a two-flop synchroniser, whatever the mask holds.
- R3: A write to the unmask alias (slot 2) clears each mask bit whose written bit is 1. Mask bits written as 0 keep their value. The mask word (slot 1) reads the result.
- R4: A write to the mask alias (slot 3) sets each mask bit whose written bit is 1. Mask bits written as 0 keep their value.
- R5: The pending word (slot 6) reads synchronised status AND NOT mask. A masked source never appears in it.
- R6: While `irq_out` is 0, it rises on the clock edge after any bank's pending word becomes nonzero. This is three edges after an unmasked input rises.
- R7: While `irq_out` is 1 and no acknowledge is written, `irq_out` stays 1, even when every pending word falls to 0.
- R8: A write with bit 0 set to the control word (word index 0x12) drops `irq_out` on that edge. On the next edge `irq_out` rises again only if some pending word is nonzero.
- R9: The unmask alias, the mask alias and the control word all read 0.
- R10: Words outside the map read 0, and writes to them have no effect. This includes every slot of a bank at or beyond `NBANK`.
- R11: Bank b's register group starts at word index 0x20 + 8·b. Within the group, slot s is at word index 0x20 + 8·b + s.
- R12: `rdata` is loaded on the edge where `rd_en` is 1 and holds its value while `rd_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NBANK*32 | Level interrupt lines, bank b at bits 32b+31..32b |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Word index of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Latched interrupt request |

## Verification
Two events can land on the same clock edge. One is an acknowledge write. The other is the synchroniser delivering a newly high, unmasked line into the pending view. The bench first holds the request high from a source that it then masks. It raises a second, unmasked line exactly two edges before the acknowledge commits, so that its synchronised level lands on the acknowledge edge. The bench expects `irq_out` low after that edge and high one edge later. This shows that the acknowledge wins for one cycle and that the new source is not lost.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int BANK_SRC   = 32;
  localparam int WORD_IDX_W = 8;
  localparam int MAX_BANKS  = 4;

  localparam logic [WORD_IDX_W-1:0] CTRL_IDX  = 8'h12;
  localparam logic [2:0]            GRP_TAG   = 3'b001;

  localparam logic [2:0] SLOT_STATUS  = 3'd0;
  localparam logic [2:0] SLOT_MASK    = 3'd1;
  localparam logic [2:0] SLOT_UNMASK  = 3'd2;
  localparam logic [2:0] SLOT_BLOCK   = 3'd3;
  localparam logic [2:0] SLOT_PENDING = 3'd6;
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stab_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;

  a_r2_two_stage: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |=> stab_q == $past(meta_q));
endmodule

// File: rtl/intc_bank.sv
module intc_bank #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] status_i,
  input  logic             unmask_we,
  input  logic             block_we,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] mask_o,
  output logic [WIDTH-1:0] pend_o
);
  logic [WIDTH-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
    end else if (block_we) begin
      mask_q <= mask_q | wdata;
    end else if (unmask_we) begin
      mask_q <= mask_q & ~wdata;
    end
  end

  assign mask_o = mask_q;
  assign pend_o = status_i & ~mask_q;

  a_r1_reset_mask: assert property (@(posedge clk)
    rst |=> (&mask_q));
  a_r4_block_sets: assert property (@(posedge clk) disable iff (rst)
    block_we |=> ((mask_q & $past(wdata)) == $past(wdata)) &&
                 ((mask_q & ~$past(wdata)) == ($past(mask_q) & ~$past(wdata))));
  a_r3_unmask_clears: assert property (@(posedge clk) disable iff (rst)
    (unmask_we && !block_we) |=> ((mask_q & $past(wdata)) == '0) &&
                 ((mask_q & ~$past(wdata)) == ($past(mask_q) & ~$past(wdata))));
  a_r3_idle_keeps: assert property (@(posedge clk) disable iff (rst)
    (!unmask_we && !block_we) |=> $stable(mask_q));
endmodule

// File: rtl/intc_irq_latch.sv
module intc_irq_latch (
  input  logic clk,
  input  logic rst,
  input  logic any_pend,
  input  logic ack,
  output logic irq_o
);
  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
    end else if (irq_q) begin
      irq_q <= !ack;
    end else begin
      irq_q <= any_pend;
    end
  end

  assign irq_o = irq_q;

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !ack) |=> irq_q);
  a_r8_drop: assert property (@(posedge clk) disable iff (rst)
    (irq_q && ack) |=> !irq_q);
  a_r6_rise: assert property (@(posedge clk) disable iff (rst)
    (!irq_q && any_pend) |=> irq_q);
  a_r6_idle: assert property (@(posedge clk) disable iff (rst)
    (!irq_q && !any_pend) |=> !irq_q);
endmodule

// File: rtl/intc_banked.sv
module intc_banked
  import intc_pkg::*;
#(
  parameter int NBANK = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NBANK*BANK_SRC-1:0]   irq_in,
  input  logic                        wr_en,
  input  logic                        rd_en,
  input  logic [WORD_IDX_W-1:0]       addr,
  input  logic [BANK_SRC-1:0]         wdata,
  output logic [BANK_SRC-1:0]         rdata,
  output logic                        irq_out
);
  localparam int NSRC = NBANK * BANK_SRC;

  logic [NSRC-1:0]     sync_lv;
  logic [BANK_SRC-1:0] mask_a   [NBANK];
  logic [BANK_SRC-1:0] pend_a   [NBANK];
  logic [NBANK-1:0]    pend_any;
  logic [1:0]          bsel;
  logic [2:0]          slot;
  logic                grp_hit;
  logic                in_bank;
  logic                ack;
  logic [BANK_SRC-1:0] rd_val;
  logic [BANK_SRC-1:0] rdata_q;

  intc_sync #(.WIDTH(NSRC)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (irq_in),
    .q_o (sync_lv)
  );

  assign bsel    = addr[4:3];
  assign slot    = addr[2:0];
  assign grp_hit = (addr[WORD_IDX_W-1:5] == GRP_TAG);
  assign in_bank = grp_hit && (int'(bsel) < NBANK);
  assign ack     = wr_en && (addr == CTRL_IDX) && wdata[0];

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic sel;
    assign sel = in_bank && (int'(bsel) == g);

    intc_bank #(.WIDTH(BANK_SRC)) u_bank (
      .clk       (clk),
      .rst       (rst),
      .status_i  (sync_lv[g*BANK_SRC +: BANK_SRC]),
      .unmask_we (wr_en && sel && (slot == SLOT_UNMASK)),
      .block_we  (wr_en && sel && (slot == SLOT_BLOCK)),
      .wdata     (wdata),
      .mask_o    (mask_a[g]),
      .pend_o    (pend_a[g])
    );

    assign pend_any[g] = |pend_a[g];
  end

  intc_irq_latch u_latch (
    .clk      (clk),
    .rst      (rst),
    .any_pend (|pend_any),
    .ack      (ack),
    .irq_o    (irq_out)
  );

  always_comb begin
    rd_val = '0;
    for (int g = 0; g < NBANK; g++) begin
      if (in_bank && (int'(bsel) == g)) begin
        case (slot)
          SLOT_STATUS:  rd_val = sync_lv[g*BANK_SRC +: BANK_SRC];
          SLOT_MASK:    rd_val = mask_a[g];
          SLOT_PENDING: rd_val = pend_a[g];
          default:      rd_val = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= rd_val;
    end
  end

  assign rdata = rdata_q;

  a_r9_alias_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && ((grp_hit && (slot == SLOT_UNMASK || slot == SLOT_BLOCK)) ||
               addr == CTRL_IDX)) |=> rdata == '0);
  a_r10_outside_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !in_bank) |=> rdata == '0);
  a_r12_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
  a_r1_reset_outputs: assert property (@(posedge clk)
    rst |=> (rdata == '0) && !irq_out);
endmodule

// File: tb/tb_intc_banked.sv
`timescale 1ns/1ps
module tb_intc_banked;
  localparam int NB = 3;
  localparam int W  = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NB*W-1:0] irq_in = '0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [7:0]    addr = '0;
  logic [W-1:0]  wdata = '0;
  logic [W-1:0]  rdata;
  logic          irq_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [W-1:0] mask_m [NB];
  logic [W-1:0] got;

  always #2.5 clk = ~clk;

  intc_banked #(.NBANK(NB)) dut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out)
  );

  function automatic logic [7:0] widx(int b, int s);
    return 8'(32 + 8 * b + s);
  endfunction

  function automatic logic [W-1:0] in_of(int b);
    return irq_in[b*W +: W];
  endfunction

  function automatic bit any_pend_m();
    bit a = 1'b0;
    for (int b = 0; b < NB; b++) a |= |(in_of(b) & ~mask_m[b]);
    return a;
  endfunction

  task automatic chk(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [W-1:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_in(int b, logic [W-1:0] v);
    irq_in[b*W +: W] = v;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %h expected %h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < NB; b++) mask_m[b] = '1;
    cycles(3);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk(irq_out == 1'b0, "R1", {31'b0, irq_out}, 0);
    chk(rdata == '0, "R1", rdata, 0);
    for (int b = 0; b < NB; b++) begin
      rd(widx(b, 1), got);
      chk(got == '1, "R1", got, '1);
    end

    // R2 status independent of mask, R5 pending empty while masked
    set_in(1, 32'hA5C3_0F18);
    cycles(3);
    rd(widx(1, 0), got);
    chk(got == 32'hA5C3_0F18, "R2", got, 32'hA5C3_0F18);
    rd(widx(1, 6), got);
    chk(got == '0, "R5", got, 0);
    chk(irq_out == 1'b0, "R6", {31'b0, irq_out}, 0);

    // R3 unmask alias, R11 map for bank 0
    wr(widx(0, 2), 32'h0000_00F0); mask_m[0] &= ~32'h0000_00F0;
    rd(widx(0, 1), got);
    chk(got == mask_m[0], "R3", got, mask_m[0]);
    rd(widx(0, 2), got);
    chk(got == '0, "R9", got, 0);
    rd(widx(0, 3), got);
    chk(got == '0, "R9", got, 0);
    rd(8'h12, got);
    chk(got == '0, "R9", got, 0);

    // R6 rise latency: input high, request after third edge
    @(negedge clk);
    set_in(0, 32'h0000_0010);
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk(irq_out == 1'b0, "R6", {31'b0, irq_out}, 0);
    @(posedge clk); @(negedge clk);
    chk(irq_out == 1'b1, "R6", {31'b0, irq_out}, 1);
    rd(widx(0, 6), got);
    chk(got == 32'h0000_0010, "R5", got, 32'h10);

    // R7 held after source drops
    set_in(0, '0);
    cycles(5);
    chk(irq_out == 1'b1, "R7", {31'b0, irq_out}, 1);
    rd(widx(0, 6), got);
    chk(got == '0, "R7", got, 0);

    // R8 acknowledge with nothing pending
    wr(8'h12, 32'h1);
    chk(irq_out == 1'b0, "R8", {31'b0, irq_out}, 0);
    cycles(1);
    chk(irq_out == 1'b0, "R8", {31'b0, irq_out}, 0);

    // R4 + R7 + R8 with a new source landing on the acknowledge edge
    set_in(0, 32'h0000_0010);
    cycles(4);
    chk(irq_out == 1'b1, "R6", {31'b0, irq_out}, 1);
    wr(widx(0, 3), 32'h0000_0010); mask_m[0] |= 32'h0000_0010;
    rd(widx(0, 1), got);
    chk(got == mask_m[0], "R4", got, mask_m[0]);
    cycles(3);
    chk(irq_out == 1'b1, "R7", {31'b0, irq_out}, 1);
    @(negedge clk);
    set_in(0, 32'h0000_0030);
    @(posedge clk);
    wr(8'h12, 32'h1);
    chk(irq_out == 1'b0, "R8", {31'b0, irq_out}, 0);
    cycles(1);
    chk(irq_out == 1'b1, "R8", {31'b0, irq_out}, 1);

    // R10 bank beyond NBANK and unmapped word
    wr(widx(3, 2), '1);
    rd(widx(3, 1), got);
    chk(got == '0, "R10", got, 0);
    wr(8'h05, '1);
    rd(8'h05, got);
    chk(got == '0, "R10", got, 0);
    rd(widx(0, 1), got);
    chk(got == mask_m[0], "R10", got, mask_m[0]);
    rd(widx(0, 4), got);
    chk(got == '0, "R10", got, 0);

    // R12 hold without rd_en
    rd(widx(1, 0), got);
    @(negedge clk); addr = widx(2, 1);
    cycles(2);
    chk(rdata == got, "R12", rdata, got);

    // Random mix against the bench model
    void'($urandom(32'd1234));
    for (int it = 0; it < 250; it++) begin
      int b = $urandom_range(0, NB - 1);
      int op = $urandom_range(0, 3);
      logic [W-1:0] v = $urandom;
      case (op)
        0: begin wr(widx(b, 2), v); mask_m[b] &= ~v; end
        1: begin wr(widx(b, 3), v); mask_m[b] |= v; end
        default: set_in(b, v & $urandom);
      endcase
      cycles(3);
      rd(widx(b, 0), got);
      chk(got == in_of(b), "R2", got, in_of(b));
      rd(widx(b, 1), got);
      chk(got == mask_m[b], "R11", got, mask_m[b]);
      rd(widx(b, 6), got);
      chk(got == (in_of(b) & ~mask_m[b]), "R5", got, in_of(b) & ~mask_m[b]);
      wr(8'h12, 32'h1);
      cycles(1);
      chk(irq_out == any_pend_m(), "R8", {31'b0, irq_out}, {31'b0, any_pend_m()});
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule